// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

A small, fully associative table of segment descriptors placed in front of an address translation path. Each slot holds two 64-bit words. The segment identifier word carries an effective segment number and a valid flag. The descriptor word carries a segment size field and the key, no-execute and page-size flags. Those flags are stored and returned here, but this block does not interpret them. A combinational lookup port takes an effective address. It returns whether a slot hit, the winning slot, and that slot's descriptor word.

A one-per-cycle operation port manages the table. It writes a slot, reads back either word of a slot, invalidates the slot matching an address, or invalidates every slot except slot 0. A rejected write or read pulses `err_o`. An invalidate that removed a live entry pulses `flush_o`, which tells a downstream translation cache to drop its contents.

Top module: `slb_array`

## Requirements
- R1: After reset every slot is invalid and both words read as 0, `lk_hit_o`, `err_o`, `flush_o` are 0 and `rd_data_o` is 0.
- R2: An identifier word has its valid flag at bit 27 and the segment number in bits 63:28. A slot whose size field (descriptor bits 63:62) is 2'b00 (256 MB) hits when its identifier word equals address bits 63:28 with bit 27 set and all other bits 0. The lookup then returns that slot and its descriptor. On a miss, `lk_desc_o` and `lk_slot_o` are 0.
- R3: A slot with size field 2'b01 (1 TB) hits when its identifier word equals address bits 63:40 with bit 27 set and all other bits 0. Each identifier is compared against both candidates, and a match counts only when it agrees with that slot's own size field.
- R4: When several slots hit, the lowest-numbered slot is returned.
- R5: A write (op 1) takes the slot from operand A bits 11:0. It stores operand A as the identifier and operand B as the descriptor. It is rejected with a one-cycle `err_o` pulse, and the table left unchanged, if operand A bits 11:0 share any set bit with (4096 - ENTRIES). For 64 entries that mask is bits 11:6.
- R6: A write is also rejected if the size field is 2'b10 or 2'b11, or if it is 2'b01 while `seg1t_en_i` is 0.
- R7: A stored identifier word keeps only bits 63:28 and bit 27 of operand A. All other bits, including the slot number, read back as 0.
- R8: Op 2 reads the identifier word and op 3 reads the descriptor word of slot operand A bits 11:0 into `rd_data_o` one cycle later. A slot number of ENTRIES or more gives `err_o` and `rd_data_o` = 0.
- R9: Invalidate-by-address (op 4) looks up operand A. On a hit it clears that slot's valid flag and pulses `flush_o`. On a miss nothing changes and no flush is raised.
- R10: Invalidate-all (op 5) clears the valid flag of every slot except slot 0. It pulses `flush_o` only if any slot other than 0 was valid before the operation.
- R11: Table updates take effect at the clock edge that ends the request cycle. In the request cycle itself, the lookup port still reflects the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation: 0 none, 1 write, 2 read identifier, 3 read descriptor, 4 invalidate by address, 5 invalidate all |
| opa_i | input | 64 | Operand A: identifier word with slot number, or address |
| opb_i | input | 64 | Operand B: descriptor word for writes |
| seg1t_en_i | input | 1 | Permits writes of 1 TB segments |
| rd_data_o | output | 64 | Word returned by the last successful read |
| err_o | output | 1 | Illegal-operand pulse |
| flush_o | output | 1 | Translation cache flush request pulse |
| lk_addr_i | input | 64 | Lookup effective address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_slot_o | output | 6 | Winning slot |
| lk_desc_o | output | 64 | Descriptor of winning slot |

## Verification
Lookup and invalidate can fall in the same cycle. The bench holds the lookup address on two overlapping entries and issues invalidate-by-address for that address in the same cycle. Just before the edge, the lookup must still report the lower duplicate slot. Just after the edge, `flush_o` must be high and the lookup must have moved to the higher duplicate. A later invalidate-all checks that slot 0 is kept while the others go, and that the second invalidate-all raises no flush.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int WORD_W  = 64;
  localparam int V_BIT   = 27;
  localparam int ID_LO   = 28;
  localparam int ID1T_LO = 40;
  localparam int SZ_HI   = 63;
  localparam int SZ_LO   = 62;
  localparam logic [1:0] SZ_256M = 2'b00;
  localparam logic [1:0] SZ_1T   = 2'b01;
  localparam logic [WORD_W-1:0] ID_KEEP =
    ~((64'd1 << ID_LO) - 64'd1) | (64'd1 << V_BIT);

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_WRITE    = 3'd1,
    OP_RD_ID    = 3'd2,
    OP_RD_DESC  = 3'd3,
    OP_INV_ADDR = 3'd4,
    OP_INV_ALL  = 3'd5
  } slb_op_e;
endpackage

// File: rtl/slb_match.sv
module slb_match
  import slb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ENTRIES-1:0][WORD_W-1:0]  id_i,
  input  logic [ENTRIES-1:0][WORD_W-1:0]  desc_i,
  input  logic [WORD_W-1:0]               addr_i,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                slot_o,
  output logic [WORD_W-1:0]               desc_o
);
  logic [WORD_W-1:0]  cand_256m, cand_1t;
  logic [ENTRIES-1:0] match;

  assign cand_256m = {addr_i[WORD_W-1:ID_LO], {ID_LO{1'b0}}} | (64'd1 << V_BIT);
  assign cand_1t   = {addr_i[WORD_W-1:ID1T_LO], {ID1T_LO{1'b0}}} | (64'd1 << V_BIT);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [1:0] sz;
    assign sz = desc_i[g][SZ_HI:SZ_LO];
    assign match[g] = ((id_i[g] == cand_256m) && (sz == SZ_256M)) ||
                      ((id_i[g] == cand_1t)   && (sz == SZ_1T));
  end

  // lowest slot wins
  always_comb begin
    slot_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) slot_o = IDX_W'(i);
    end
    hit_o  = |match;
    desc_o = hit_o ? desc_i[slot_o] : '0;
  end

  assert_hit_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> id_i[slot_o][V_BIT]);
endmodule

// File: rtl/slb_store.sv
module slb_store
  import slb_pkg::*;
#(
  parameter int ENTRIES = 64,  // power of two, 2..2048
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  slb_op_e                         op_i,
  input  logic [WORD_W-1:0]               opa_i,
  input  logic [WORD_W-1:0]               opb_i,
  input  logic                            seg1t_en_i,
  input  logic                            inv_hit_i,
  input  logic [IDX_W-1:0]                inv_slot_i,
  output logic [ENTRIES-1:0][WORD_W-1:0]  id_o,
  output logic [ENTRIES-1:0][WORD_W-1:0]  desc_o,
  output logic [WORD_W-1:0]               rd_data_o,
  output logic                            err_o,
  output logic                            flush_o
);
  localparam logic [11:0] SLOT_RSV = 12'(4096 - ENTRIES);

  logic [ENTRIES-1:0][WORD_W-1:0] id_q, desc_q;
  logic [IDX_W-1:0] slot;
  logic wr_bad, rd_bad, upper_valid;

  assign slot   = opa_i[IDX_W-1:0];
  assign wr_bad = (|(opa_i[11:0] & SLOT_RSV)) | opb_i[SZ_HI] |
                  (opb_i[SZ_LO] & ~seg1t_en_i);
  assign rd_bad = opa_i[11:0] >= 12'(ENTRIES);

  always_comb begin
    upper_valid = 1'b0;
    for (int i = 1; i < ENTRIES; i++) upper_valid |= id_q[i][V_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q      <= '0;
      desc_q    <= '0;
      rd_data_o <= '0;
      err_o     <= 1'b0;
      flush_o   <= 1'b0;
    end else begin
      err_o   <= 1'b0;
      flush_o <= 1'b0;
      case (op_i)
        OP_WRITE: begin
          if (wr_bad) err_o <= 1'b1;
          else begin
            id_q[slot]   <= opa_i & ID_KEEP;
            desc_q[slot] <= opb_i;
          end
        end
        OP_RD_ID, OP_RD_DESC: begin
          if (rd_bad) begin
            err_o     <= 1'b1;
            rd_data_o <= '0;
          end else begin
            rd_data_o <= (op_i == OP_RD_ID) ? id_q[slot] : desc_q[slot];
          end
        end
        OP_INV_ADDR: begin
          if (inv_hit_i) begin
            id_q[inv_slot_i][V_BIT] <= 1'b0;
            flush_o <= 1'b1;
          end
        end
        OP_INV_ALL: begin
          for (int i = 1; i < ENTRIES; i++) id_q[i][V_BIT] <= 1'b0;
          flush_o <= upper_valid;
        end
        default: ;
      endcase
    end
  end

  assign id_o   = id_q;
  assign desc_o = desc_q;

  assert_flush_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> ($past(op_i) == OP_INV_ADDR || $past(op_i) == OP_INV_ALL));

  assert_err_no_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(id_q) && $stable(desc_q)));

  assert_slot0_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INV_ALL) |=> $stable(id_q[0][V_BIT]));

  assert_inv_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_INV_ADDR && inv_hit_i) |=> !id_q[$past(inv_slot_i)][V_BIT]);
endmodule

// File: rtl/slb_array.sv
module slb_array
  import slb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [63:0]       opa_i,
  input  logic [63:0]       opb_i,
  input  logic              seg1t_en_i,
  output logic [63:0]       rd_data_o,
  output logic              err_o,
  output logic              flush_o,
  input  logic [63:0]       lk_addr_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_slot_o,
  output logic [63:0]       lk_desc_o
);
  logic [ENTRIES-1:0][WORD_W-1:0] id_w, desc_w;
  logic                            inv_hit;
  logic [IDX_W-1:0]                inv_slot;
  logic [WORD_W-1:0]               inv_desc;
  slb_op_e                         op;

  assign op = slb_op_e'(op_i);

  slb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .clk_i, .rst_ni, .id_i(id_w), .desc_i(desc_w), .addr_i(lk_addr_i),
    .hit_o(lk_hit_o), .slot_o(lk_slot_o), .desc_o(lk_desc_o)
  );

  slb_match #(.ENTRIES(ENTRIES)) u_inv_match (
    .clk_i, .rst_ni, .id_i(id_w), .desc_i(desc_w), .addr_i(opa_i),
    .hit_o(inv_hit), .slot_o(inv_slot), .desc_o(inv_desc)
  );

  slb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk_i, .rst_ni, .op_i(op), .opa_i, .opb_i, .seg1t_en_i,
    .inv_hit_i(inv_hit), .inv_slot_i(inv_slot),
    .id_o(id_w), .desc_o(desc_w),
    .rd_data_o, .err_o, .flush_o
  );

  assert_err_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !flush_o);

  assert_inv_desc_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_hit |-> !inv_desc[SZ_HI]);
endmodule

// File: tb/slb_array_tb.sv
module slb_array_tb;
  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] opa;
    logic [63:0] opb;
    logic        s1;
    logic        err;
    logic        flush;
    logic        chk_rd;
    logic [63:0] rd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 64'h1234_5678_9800_0000, 64'h0000_0000_0000_ABCD, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 8'd5},  // R5
    '{3'd2, 64'h0,                   64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h1234_5678_9800_0000, 8'd8},  // R8
    '{3'd1, 64'h0000_0100_0810_0005, 64'h4000_0000_0000_0077, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 8'd7},  // R7
    '{3'd2, 64'h5,                   64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h0000_0100_0800_0000, 8'd7},  // R7
    '{3'd3, 64'h5,                   64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h4000_0000_0000_0077, 8'd8},  // R8
    '{3'd1, 64'h0000_0200_0800_0040, 64'h0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 8'd5},                    // R5
    '{3'd1, 64'h0000_0200_0800_0006, 64'h8000_0000_0000_0001, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 8'd6},  // R6
    '{3'd3, 64'h6,                   64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h0, 8'd6},                    // R6
    '{3'd1, 64'h0000_0200_0800_0007, 64'h4000_0000_0000_0002, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 8'd6},  // R6
    '{3'd2, 64'h7,                   64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h0, 8'd6},                    // R6
    '{3'd2, 64'h3F,                  64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h0, 8'd8},                    // R8
    '{3'd2, 64'h40,                  64'h0, 1'b1, 1'b1, 1'b0, 1'b1, 64'h0, 8'd8},                    // R8
    '{3'd2, 64'h1000,                64'h0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h1234_5678_9800_0000, 8'd8},  // R8
    '{3'd1, 64'h0000_0100_0800_0800, 64'h0, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0, 8'd5},                    // R5
    '{3'd1, 64'h0000_0200_0800_0008, 64'h8, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 8'd3},                    // R3
    '{3'd1, 64'h0000_0300_0800_000A, 64'h10, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 8'd4},                   // R4
    '{3'd1, 64'h0000_0300_0800_0004, 64'h11, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 8'd4},                   // R4
    '{3'd1, 64'h0000_0400_0800_003F, 64'h3F, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 8'd5}                    // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [63:0] opa = '0, opb = '0, lk_addr = '0;
  logic        s1 = 1'b1;
  logic [63:0] rd_data, lk_desc;
  logic        err, flush, lk_hit;
  logic [5:0]  lk_slot;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slb_array u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .opa_i(opa), .opb_i(opb),
    .seg1t_en_i(s1), .rd_data_o(rd_data), .err_o(err), .flush_o(flush),
    .lk_addr_i(lk_addr), .lk_hit_o(lk_hit), .lk_slot_o(lk_slot), .lk_desc_o(lk_desc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic one_t);
    op = o; opa = a; opb = b; s1 = one_t;
    @(posedge clk); #1;
    op = 3'd0;
  endtask

  task automatic look(input string tag, input logic [63:0] a, input logic hit,
                      input logic [5:0] slot, input logic [63:0] desc);
    lk_addr = a; #1;
    chk({tag, " hit"}, {63'd0, lk_hit}, {63'd0, hit});
    chk({tag, " slot"}, {58'd0, lk_slot}, {58'd0, slot});
    chk({tag, " desc"}, lk_desc, desc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 err", {63'd0, err}, 64'd0);
    chk("R1 flush", {63'd0, flush}, 64'd0);
    chk("R1 rd", rd_data, 64'd0);
    chk("R1 hit", {63'd0, lk_hit}, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    do_op(3'd2, 64'h9, 64'h0, 1'b1);
    chk("R1 readback", rd_data, 64'd0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].op, VEC[i].opa, VEC[i].opb, VEC[i].s1);
      checks++;
      if (err !== VEC[i].err || flush !== VEC[i].flush ||
          (VEC[i].chk_rd && rd_data !== VEC[i].rd)) begin
        failures++;
        $display("FAIL R%0d vector %0d actual err=%b flush=%b rd=%h expected err=%b flush=%b rd=%h",
                 VEC[i].req, i, err, flush, rd_data, VEC[i].err, VEC[i].flush, VEC[i].rd);
      end
    end
    s1 = 1'b1;

    look("R2 256M", 64'h1234_5678_9123_4567, 1'b1, 6'd0, 64'h0000_0000_0000_ABCD);
    look("R3 1T", 64'h0000_01AB_CDEF_0123, 1'b1, 6'd5, 64'h4000_0000_0000_0077);
    look("R3 size mismatch", 64'h0000_0200_1000_0000, 1'b0, 6'd0, 64'h0);
    look("R3 256M own", 64'h0000_0200_0FFF_FFFF, 1'b1, 6'd8, 64'h8);
    look("R5 top slot", 64'h0000_0400_0000_0010, 1'b1, 6'd63, 64'h3F);
    look("R4 priority", 64'h0000_0300_0000_0000, 1'b1, 6'd4, 64'h11);

    // R11 lookup and invalidate in the same cycle
    op = 3'd4; opa = 64'h0000_0300_0000_0000; #1;
    chk("R11 pre-edge slot", {58'd0, lk_slot}, 64'd4);
    @(posedge clk); #1; op = 3'd0;
    chk("R9 flush on hit", {63'd0, flush}, 64'd1);
    chk("R11 post-edge slot", {58'd0, lk_slot}, 64'd10);
    chk("R11 post-edge desc", lk_desc, 64'h10);

    do_op(3'd4, 64'hFFFF_0000_0000_0000, 64'h0, 1'b1);
    chk("R9 miss no flush", {63'd0, flush}, 64'd0);
    chk("R9 miss no err", {63'd0, err}, 64'd0);
    look("R9 miss keeps", 64'h0000_0300_0000_0000, 1'b1, 6'd10, 64'h10);

    do_op(3'd5, 64'h0, 64'h0, 1'b1);
    chk("R10 flush", {63'd0, flush}, 64'd1);
    look("R10 slot0 kept", 64'h1234_5678_9000_0000, 1'b1, 6'd0, 64'h0000_0000_0000_ABCD);
    look("R10 1T gone", 64'h0000_01AB_CDEF_0123, 1'b0, 6'd0, 64'h0);
    look("R10 slot10 gone", 64'h0000_0300_0000_0000, 1'b0, 6'd0, 64'h0);
    do_op(3'd5, 64'h0, 64'h0, 1'b1);
    chk("R10 no flush when upper empty", {63'd0, flush}, 64'd0);
    do_op(3'd2, 64'h5, 64'h0, 1'b1);
    chk("R10 valid cleared", rd_data, 64'h0000_0100_0000_0000);

    do_op(3'd4, 64'h1234_5678_9ABC_0000, 64'h0, 1'b1);
    chk("R9 slot0 flush", {63'd0, flush}, 64'd1);
    look("R9 slot0 gone", 64'h1234_5678_9000_0000, 1'b0, 6'd0, 64'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule